// File: doc/BRIEF.md
# Panel Self-Refresh Sequencer

This block runs on the source side of a display link. It takes the link into self-refresh and brings it back out. While the panel holds its own copy of the last frame, the source can stop sending frames. Software enables the block and then asks for entry. The block then counts vertical blanks that pass without a frame change. Once enough static frames have gone by, it moves to the active state by itself, and the source link may go quiet.

While the block is active, software can ask for a single-frame update to push one changed frame to the panel, or it can request an exit. After an exit the block waits for the wake handshake to finish and then settles back to the inactive state. A new entry request is accepted only once the block is idle again. The status is a registered 3-bit state code and an in-transition flag. The block also drives a coded wake-time selection and a fixed maximum sleep-time field for the link layer.

Top module: `psr_sr_ctrl`

## Requirements
- R1: After synchronous reset the status state is 0 (off), the in-transition flag is 0, the link-idle output is 0 and the single-frame-update pending bit is 0. The state code takes only the values 0 off, 1 inactive, 2 entering (static frame sent), 3 active with no remote-buffer update, 4 active with a single-frame update, and 5 exit.
- R2: With `ctl_enable` high, state 0 moves to state 1 on the next clock and never goes directly to any other state. With `ctl_enable` low, the block is in state 0 with the flag cleared and the pending bit cleared after the next clock, whatever state it was in.
- R3: An `ctl_activate` pulse in state 1 moves the block to state 2 on the next clock. In state 1 without it, the block stays in 1. An activate pulse in any other state is dropped and is not remembered.
- R4: In state 2 the block counts vertical-blank strobes. When the count reaches the threshold, the block moves to state 3 on the following clock without any software action.
- R5: The idle threshold is the larger of 6 and `ctl_idle_frames`.
- R6: A `frame_update` strobe clears the idle count. If it arrives in the same cycle as a vertical blank, the count is cleared and that vertical blank is not counted.
- R7: `exit_req` in state 3 moves the block to state 5 on the next clock, skipping state 4. It does the same from state 2 and state 4. Exit takes priority over a pending single-frame update.
- R8: The block stays in state 5 until `exit_ack`, then returns to state 1. An activate pulse seen during state 5 does not cause entry after the return.
- R9: A `ctl_sfu_req` pulse in any state other than 0 sets the pending bit. In state 3, a pending bit moves the block to state 4. In state 4, the next vertical blank returns the block to state 3 and clears the bit.
- R10: `wake_code` is a registered copy of the encoded `ctl_wake_sel`. A value above 5 gives code 3 (2500 us), above 1 gives code 2 (500 us), above 0 gives code 1 (100 us), and 0 gives code 0 (0 us).
- R11: `max_sleep` is constantly 0x1F.
- R12: `sts_in_trans` is 1 exactly when the state is 2, 4 or 5.
- R13: `link_idle` is 1 exactly when the state is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Source enable level |
| ctl_activate | input | 1 | Entry request pulse |
| ctl_sfu_req | input | 1 | Single-frame-update request pulse |
| ctl_wake_sel | input | WAKE_W (4) | Requested wake time |
| ctl_idle_frames | input | IDLE_W (4) | Programmed idle-frame count |
| vblank | input | 1 | Vertical-blank strobe |
| frame_update | input | 1 | Frame-content change strobe |
| exit_req | input | 1 | Exit request strobe |
| exit_ack | input | 1 | Wake handshake done |
| sts_state | output | 3 | Registered state code |
| sts_in_trans | output | 1 | Registered in-transition flag |
| link_idle | output | 1 | Source may stop sending frames |
| sfu_pending | output | 1 | Single-frame update pending |
| wake_code | output | 2 | Encoded wake time |
| max_sleep | output | 5 | Maximum sleep-time field |

## Verification
Two pairs of events can land on the same clock edge. The first is a frame update and a vertical blank while the block is entering. The bench drives both in one cycle after five counted blanks. It then counts how many further blanks are needed before state 3 appears, which shows whether the coincident blank was dropped. The second is a pending single-frame update and an exit request in state 3. The bench raises the exit in the first cycle the pending bit is visible and expects state 5, not state 4, with the pending bit still set.

// File: rtl/psr_sr_pkg.sv
package psr_sr_pkg;

    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_IDLE     = 3'd1,
        PS_ENTERING = 3'd2,
        PS_ACTIVE   = 3'd3,
        PS_SFU      = 3'd4,
        PS_EXIT     = 3'd5
    } psr_state_e;

    typedef enum logic [1:0] {
        WK_0US    = 2'd0,
        WK_100US  = 2'd1,
        WK_500US  = 2'd2,
        WK_2500US = 2'd3
    } wake_code_e;

    localparam int          MIN_IDLE_FRAMES = 6;
    localparam logic [4:0]  MAX_SLEEP_VAL   = 5'h1F;

    function automatic wake_code_e wake_encode(input logic [7:0] t);
        if (t > 8'd5)      return WK_2500US;
        else if (t > 8'd1) return WK_500US;
        else if (t > 8'd0) return WK_100US;
        else               return WK_0US;
    endfunction

    function automatic logic is_transitional(input psr_state_e s);
        return (s == PS_ENTERING) || (s == PS_SFU) || (s == PS_EXIT);
    endfunction

endpackage

// File: rtl/psr_cfg.sv
module psr_cfg
    import psr_sr_pkg::*;
#(
    parameter int IDLE_W = 4,
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAKE_W-1:0] wake_sel,
    input  logic [IDLE_W-1:0] idle_prog,
    output wake_code_e        wake_code_o,
    output logic [IDLE_W-1:0] idle_thr_o
);
    localparam logic [IDLE_W-1:0] MIN_THR = IDLE_W'(MIN_IDLE_FRAMES);

    logic [7:0] sel_ext;

    generate
        if (WAKE_W >= 8) begin : g_wide
            assign sel_ext = (|wake_sel[WAKE_W-1:0] & (wake_sel > WAKE_W'(255)))
                             ? 8'hFF : wake_sel[7:0];
        end else begin : g_narrow
            assign sel_ext = 8'(wake_sel);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) wake_code_o <= WK_0US;
        else     wake_code_o <= wake_encode(sel_ext);
    end

    always_comb begin
        idle_thr_o = (idle_prog > MIN_THR) ? idle_prog : MIN_THR;
    end

endmodule

// File: rtl/psr_idle_cnt.sv
module psr_idle_cnt #(
    parameter int IDLE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              count_en,
    input  logic              vblank,
    input  logic              update,
    input  logic [IDLE_W-1:0] thr,
    output logic              reached
);
    logic [IDLE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !count_en || update)   cnt_q <= '0;
        else if (vblank && (cnt_q < thr)) cnt_q <= cnt_q + 1'b1;
    end

    assign reached = (cnt_q >= thr);

endmodule

// File: rtl/psr_fsm.sv
module psr_fsm
    import psr_sr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       activate,
    input  logic       sfu_req,
    input  logic       vblank,
    input  logic       exit_req,
    input  logic       exit_ack,
    input  logic       idle_reached,
    output psr_state_e state_o,
    output logic       in_trans_o,
    output logic       link_idle_o,
    output logic       sfu_pend_o
);
    psr_state_e st_q, st_d;
    logic       sfu_d;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = PS_OFF;
        end else begin
            case (st_q)
                PS_OFF:      st_d = PS_IDLE;
                PS_IDLE:     if (activate) st_d = PS_ENTERING;
                PS_ENTERING: begin
                    if (exit_req)          st_d = PS_EXIT;
                    else if (idle_reached) st_d = PS_ACTIVE;
                end
                PS_ACTIVE: begin
                    if (exit_req)        st_d = PS_EXIT;
                    else if (sfu_pend_o) st_d = PS_SFU;
                end
                PS_SFU: begin
                    if (exit_req)    st_d = PS_EXIT;
                    else if (vblank) st_d = PS_ACTIVE;
                end
                PS_EXIT:     if (exit_ack) st_d = PS_IDLE;
                default:     st_d = PS_OFF;
            endcase
        end
    end

    always_comb begin
        sfu_d = sfu_pend_o;
        if (!enable)                            sfu_d = 1'b0;
        else if (sfu_req && st_q != PS_OFF)     sfu_d = 1'b1;
        else if (st_q == PS_SFU && st_d == PS_ACTIVE) sfu_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= PS_OFF;
            in_trans_o  <= 1'b0;
            link_idle_o <= 1'b0;
            sfu_pend_o  <= 1'b0;
        end else begin
            st_q        <= st_d;
            in_trans_o  <= is_transitional(st_d);
            link_idle_o <= (st_d == PS_ACTIVE);
            sfu_pend_o  <= sfu_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/psr_sr_ctrl.sv
module psr_sr_ctrl
    import psr_sr_pkg::*;
#(
    parameter int IDLE_W = 4,
    parameter int WAKE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_enable,
    input  logic              ctl_activate,
    input  logic              ctl_sfu_req,
    input  logic [WAKE_W-1:0] ctl_wake_sel,
    input  logic [IDLE_W-1:0] ctl_idle_frames,
    input  logic              vblank,
    input  logic              frame_update,
    input  logic              exit_req,
    input  logic              exit_ack,
    output logic [2:0]        sts_state,
    output logic              sts_in_trans,
    output logic              link_idle,
    output logic              sfu_pending,
    output logic [1:0]        wake_code,
    output logic [4:0]        max_sleep
);
    psr_state_e        state;
    wake_code_e        wcode;
    logic [IDLE_W-1:0] idle_thr;
    logic              idle_reached;

    psr_cfg #(.IDLE_W(IDLE_W), .WAKE_W(WAKE_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wake_sel    (ctl_wake_sel),
        .idle_prog   (ctl_idle_frames),
        .wake_code_o (wcode),
        .idle_thr_o  (idle_thr)
    );

    psr_idle_cnt #(.IDLE_W(IDLE_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .count_en (state == PS_ENTERING),
        .vblank   (vblank),
        .update   (frame_update),
        .thr      (idle_thr),
        .reached  (idle_reached)
    );

    psr_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .enable       (ctl_enable),
        .activate     (ctl_activate),
        .sfu_req      (ctl_sfu_req),
        .vblank       (vblank),
        .exit_req     (exit_req),
        .exit_ack     (exit_ack),
        .idle_reached (idle_reached),
        .state_o      (state),
        .in_trans_o   (sts_in_trans),
        .link_idle_o  (link_idle),
        .sfu_pend_o   (sfu_pending)
    );

    assign sts_state = state;
    assign wake_code = wcode;
    assign max_sleep = MAX_SLEEP_VAL;

endmodule

// File: rtl/psr_sr_ctrl_chk.sv
module psr_sr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_enable,
    input logic       ctl_activate,
    input logic       exit_req,
    input logic       exit_ack,
    input logic [2:0] sts_state,
    input logic       sts_in_trans,
    input logic       link_idle,
    input logic [4:0] max_sleep
);
    AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (rst)
        sts_state <= 3'd5); // R1

    AST_DISABLE_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctl_enable |=> (sts_state == 3'd0) && !sts_in_trans); // R2

    AST_OFF_TO_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        (ctl_enable && sts_state == 3'd0) |=> sts_state == 3'd1); // R2

    AST_HOLD_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        (ctl_enable && sts_state == 3'd1 && !ctl_activate) |=> sts_state == 3'd1); // R3

    AST_EXIT_SKIPS_SFU: assert property (@(posedge clk) disable iff (rst)
        (ctl_enable && sts_state == 3'd3 && exit_req) |=> sts_state == 3'd5); // R7

    AST_EXIT_WAITS_ACK: assert property (@(posedge clk) disable iff (rst)
        (ctl_enable && sts_state == 3'd5 && !exit_ack) |=> sts_state == 3'd5); // R8

    AST_EXIT_RETURNS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ctl_enable && sts_state == 3'd5 && exit_ack) |=> sts_state == 3'd1); // R8

    AST_FLAG_MATCHES_STATE: assert property (@(posedge clk) disable iff (rst)
        sts_in_trans == (sts_state == 3'd2 || sts_state == 3'd4 || sts_state == 3'd5)); // R12

    AST_LINK_IDLE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        link_idle == (sts_state == 3'd3)); // R13

    AST_MAX_SLEEP_FIXED: assert property (@(posedge clk) disable iff (rst)
        max_sleep == 5'h1F); // R11

endmodule

bind psr_sr_ctrl psr_sr_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl_enable   (ctl_enable),
    .ctl_activate (ctl_activate),
    .exit_req     (exit_req),
    .exit_ack     (exit_ack),
    .sts_state    (sts_state),
    .sts_in_trans (sts_in_trans),
    .link_idle    (link_idle),
    .max_sleep    (max_sleep)
);

// File: tb/test_psr_sr_ctrl.sv
module test_psr_sr_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_enable = 1'b0;
    logic       ctl_activate = 1'b0;
    logic       ctl_sfu_req = 1'b0;
    logic [3:0] ctl_wake_sel = '0;
    logic [3:0] ctl_idle_frames = '0;
    logic       vblank = 1'b0;
    logic       frame_update = 1'b0;
    logic       exit_req = 1'b0;
    logic       exit_ack = 1'b0;
    logic [2:0] sts_state;
    logic       sts_in_trans;
    logic       link_idle;
    logic       sfu_pending;
    logic [1:0] wake_code;
    logic [4:0] max_sleep;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    psr_sr_ctrl i_psr_sr_ctrl (.*);

    // {wake_sel[3:0], expected code[1:0]}  (R10)
    localparam logic [5:0] WAKE_VEC [10] = '{
        {4'd0, 2'd0}, {4'd1, 2'd1}, {4'd2, 2'd2}, {4'd3, 2'd2}, {4'd4, 2'd2},
        {4'd5, 2'd2}, {4'd6, 2'd3}, {4'd7, 2'd3}, {4'd9, 2'd3}, {4'd15, 2'd3}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic vbl();
        vblank = 1'b1; tick();
        vblank = 1'b0; tick();
    endtask

    task automatic pulse_act();
        ctl_activate = 1'b1; tick();
        ctl_activate = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 state", sts_state, 0);
        chk("R1 flag", sts_in_trans, 0);
        chk("R1 link_idle", link_idle, 0);
        chk("R1 pending", sfu_pending, 0);
        chk("R11 max_sleep", max_sleep, 'h1F);

        // R10 wake code table
        for (int i = 0; i < 10; i++) begin
            ctl_wake_sel = WAKE_VEC[i][5:2];
            tick();
            chk("R10 wake_code", wake_code, WAKE_VEC[i][1:0]);
        end

        // R2 enable: 0 -> 1 only; sfu ignored in state 0
        ctl_enable = 1'b1;
        ctl_sfu_req = 1'b1;
        tick();
        ctl_sfu_req = 1'b0;
        chk("R2 enable to inactive", sts_state, 1);
        tick();
        chk("R3 stays inactive", sts_state, 1);
        chk("R9 pending not set from off", sfu_pending, 0);

        // R3 / R5 / R4 : threshold max(6,3) = 6
        ctl_idle_frames = 4'd3;
        pulse_act();
        chk("R3 activate to entering", sts_state, 2);
        chk("R12 flag in entering", sts_in_trans, 1);
        for (int i = 0; i < 5; i++) vbl();
        chk("R5 still entering after 5 blanks", sts_state, 2);
        vbl();
        chk("R4 auto to active", sts_state, 3);
        chk("R13 link_idle in active", link_idle, 1);
        chk("R12 flag clear in active", sts_in_trans, 0);

        // R9 single-frame update
        ctl_sfu_req = 1'b1; tick(); ctl_sfu_req = 1'b0;
        chk("R9 pending set", sfu_pending, 1);
        chk("R9 still active", sts_state, 3);
        tick();
        chk("R9 to sfu state", sts_state, 4);
        chk("R13 link_idle off in sfu", link_idle, 0);
        vblank = 1'b1; tick(); vblank = 1'b0;
        chk("R9 back to active", sts_state, 3);
        chk("R9 pending cleared", sfu_pending, 0);

        // R7 / R8 exit
        exit_req = 1'b1; tick(); exit_req = 1'b0;
        chk("R7 active to exit", sts_state, 5);
        chk("R12 flag in exit", sts_in_trans, 1);
        pulse_act();
        chk("R8 waits for ack", sts_state, 5);
        exit_ack = 1'b1; tick(); exit_ack = 1'b0;
        chk("R8 return to inactive", sts_state, 1);
        tick(); tick();
        chk("R8 activate in exit refused", sts_state, 1);

        // R6 update coincident with blank, threshold 9
        ctl_idle_frames = 4'd9;
        pulse_act();
        for (int i = 0; i < 5; i++) vbl();
        vblank = 1'b1; frame_update = 1'b1; tick();
        vblank = 1'b0; frame_update = 1'b0; tick();
        for (int i = 0; i < 8; i++) vbl();
        chk("R6 count cleared by update", sts_state, 2);
        vbl();
        chk("R6 R5 active after 9 blanks", sts_state, 3);

        // R7 exit priority over pending update
        ctl_sfu_req = 1'b1; tick(); ctl_sfu_req = 1'b0;
        exit_req = 1'b1; tick(); exit_req = 1'b0;
        chk("R7 exit beats sfu", sts_state, 5);
        chk("R9 pending kept", sfu_pending, 1);
        exit_ack = 1'b1; tick(); exit_ack = 1'b0;
        chk("R8 inactive again", sts_state, 1);

        // R7 exit from entering
        pulse_act();
        exit_req = 1'b1; tick(); exit_req = 1'b0;
        chk("R7 entering to exit", sts_state, 5);
        exit_ack = 1'b1; tick(); exit_ack = 1'b0;

        // R2 disable from entering
        pulse_act();
        chk("R3 entering", sts_state, 2);
        ctl_enable = 1'b0; tick();
        chk("R2 forced off", sts_state, 0);
        chk("R2 flag dropped", sts_in_trans, 0);
        chk("R2 pending cleared", sfu_pending, 0);
        ctl_enable = 1'b1; ctl_activate = 1'b1; tick(); ctl_activate = 1'b0;
        chk("R2 off goes to inactive only", sts_state, 1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule